// File: doc/BRIEF.md
# Normalizing Field-Select Shifter

A purely combinational shift unit for a 32-bit data word. A shift array picks a contiguous 32-bit field, either as a circular rotate of the input or as a window into a 96-bit value. That value is 32 copies of the sign bit, then the input word, then 32 zeros. A two-way multiplexer presents the upper or the lower 16 bits of the field. A separate leading-digit encoder looks at the input and reports how far it must be shifted left to bring its first significant bit to the top.

The encoder first flips every input bit when the sign input is high, so negative two's-complement values are also handled. With the normalize control set, its result becomes the shift amount used inside the block. Full 32-bit normalization then needs no external wiring: set fill mode and left direction, and read both halves. The result port carries a valid flag in place of a three-state enable. There is no handshake, because the block has no storage and nothing to stall.

Top module: `lsh_norm_shifter`

## Requirements
- R1: In fill mode, the 6-bit signed value {shift_right, shift_code} is a left-shift amount. Code k with shift_right=0 shifts left by k. With shift_right=1, the 5-bit code is the two's complement of a right shift, so 11111 shifts right by one.
- R2: In wrap mode (wrap_mode=1), bit j of the 32-bit field equals data_in[(j - code) mod 32]. shift_right has no effect.
- R3: In fill mode with shift_right=0, field positions below the shift amount are zero.
- R4: In fill mode with shift_right=1, vacated upper positions take sign_in. Code 00000 with shift_right=1 makes every field bit equal sign_in.
- R5: upper_sel=1 presents field bits 31..16 on result. upper_sel=0 presents bits 15..0.
- R6: lead_code is the left shift that brings the highest set bit of (data_in XOR sign_in) to bit 31. A set bit 31 gives 00000. Only bit 0 set, or no bit set, gives 11111.
- R7: The shift array uses raw data_in. sign_in changes the field only through the fill value.
- R8: With norm_en=1, lead_code replaces shift_code as the 5-bit shift amount.
- R9: With out_en=0, result is zero and result_valid is 0. lead_code still follows R6. With out_en=1, result_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 32 | Data word to shift and encode |
| sign_in | input | 1 | Right-fill value, and encoder inversion control |
| shift_code | input | 5 | External shift amount |
| shift_right | input | 1 | Sign bit of the 6-bit amount in fill mode |
| wrap_mode | input | 1 | 1 = rotate, 0 = sign/zero fill |
| norm_en | input | 1 | Use the encoder result as the shift amount |
| upper_sel | input | 1 | 1 = upper 16 field bits, 0 = lower 16 |
| out_en | input | 1 | Result enable |
| result | output | 16 | Selected half of the shifted field |
| result_valid | output | 1 | High when out_en is high |
| lead_code | output | 5 | Normalizing left-shift amount |

## Verification
The checks are immediate assertions evaluated on settled combinational values. They assume every input holds a known 0 or 1 once it has been driven. The normalization assertion also assumes the intended usage of fill mode, left direction and a zero sign. The stimulus sets all inputs together away from the clock edge and samples one nanosecond later. Normalize scenarios apply only that combination, while the other scenarios sweep every code and both directions freely.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  typedef enum logic {
    FIELD_FILL = 1'b0,
    FIELD_WRAP = 1'b1
  } field_mode_e;
endpackage

// File: rtl/lsh_lead_enc.sv
module lsh_lead_enc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  word,
  input  logic          invert,
  output logic [CW-1:0] lead
);
  logic [W-1:0] mag;

  assign mag = word ^ {W{invert}};

  // ascending scan: the highest set bit is written last and wins
  always_comb begin
    lead = CW'(W - 1);
    for (int i = 0; i < W; i++) begin
      if (mag[i]) lead = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/lsh_field_array.sv
module lsh_field_array
  import lsh_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  word,
  input  logic          fill_sign,
  input  logic [CW-1:0] amount,
  input  logic          neg,
  input  field_mode_e   mode,
  output logic [W-1:0]  field
);
  localparam int EW = 3 * W;
  localparam int IW = $clog2(EW);

  logic [EW-1:0] ext;
  assign ext = {{W{fill_sign}}, word, {W{1'b0}}};

  for (genvar j = 0; j < W; j++) begin : g_bit
    logic [CW-1:0] rot_idx;
    logic [IW-1:0] win_idx;
    int            signed_amt;

    always_comb begin
      signed_amt = neg ? (int'(amount) - W) : int'(amount);
      rot_idx    = CW'(j - int'(amount));
      win_idx    = IW'(W + j - signed_amt);
      if (mode == FIELD_WRAP) field[j] = word[rot_idx];
      else                    field[j] = ext[win_idx];
    end
  end
endmodule

// File: rtl/lsh_half_sel.sv
module lsh_half_sel #(
  parameter int W = 32,
  parameter int H = W / 2
) (
  input  logic [W-1:0] field,
  input  logic         upper,
  input  logic         enable,
  output logic [H-1:0] half,
  output logic         valid
);
  assign valid = enable;
  assign half  = !enable ? '0 : (upper ? field[W-1:H] : field[H-1:0]);
endmodule

// File: rtl/lsh_norm_shifter.sv
module lsh_norm_shifter
  import lsh_pkg::*;
#(
  parameter int W  = 32,
  parameter int H  = W / 2,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  data_in,
  input  logic          sign_in,
  input  logic [CW-1:0] shift_code,
  input  logic          shift_right,
  input  logic          wrap_mode,
  input  logic          norm_en,
  input  logic          upper_sel,
  input  logic          out_en,
  output logic [H-1:0]  result,
  output logic          result_valid,
  output logic [CW-1:0] lead_code
);
  logic [CW-1:0] eff_code;
  logic [W-1:0]  field;
  field_mode_e   mode;

  lsh_lead_enc #(.W(W), .CW(CW)) u_enc (
    .word   (data_in),
    .invert (sign_in),
    .lead   (lead_code)
  );

  assign eff_code = norm_en ? lead_code : shift_code;
  assign mode     = wrap_mode ? FIELD_WRAP : FIELD_FILL;

  lsh_field_array #(.W(W), .CW(CW)) u_arr (
    .word      (data_in),
    .fill_sign (sign_in),
    .amount    (eff_code),
    .neg       (shift_right),
    .mode      (mode),
    .field     (field)
  );

  lsh_half_sel #(.W(W), .H(H)) u_half (
    .field  (field),
    .upper  (upper_sel),
    .enable (out_en),
    .half   (result),
    .valid  (result_valid)
  );
endmodule

// File: rtl/lsh_norm_shifter_chk.sv
module lsh_norm_shifter_chk #(
  parameter int W  = 32,
  parameter int H  = W / 2,
  parameter int CW = $clog2(W)
) (
  input logic [W-1:0]  data_in,
  input logic          sign_in,
  input logic [CW-1:0] shift_code,
  input logic          shift_right,
  input logic          wrap_mode,
  input logic          norm_en,
  input logic          upper_sel,
  input logic          out_en,
  input logic [H-1:0]  result,
  input logic          result_valid,
  input logic [CW-1:0] lead_code
);
  logic [W-1:0] mag;
  assign mag = data_in ^ {W{sign_in}};

  always_comb begin
    assert_idle_zero_R9: assert (out_en || (result == '0 && !result_valid))
      else $error("idle result not cleared");
    assert_valid_follows_R9: assert (!out_en || result_valid)
      else $error("valid missing while enabled");
    assert_lead_top_R6: assert (!mag[W-1] || lead_code == '0)
      else $error("top bit set but lead code nonzero");
    assert_lead_pos_R6: assert ((mag == '0) ? (lead_code == CW'(W - 1))
                                : ((mag >> (W - 1 - int'(lead_code))) == W'(1)))
      else $error("lead code does not locate highest bit");
    assert_wrap_zero_R2: assert (!(out_en && wrap_mode && !norm_en && shift_code == '0)
                                 || result == (upper_sel ? data_in[W-1:H] : data_in[H-1:0]))
      else $error("zero rotate altered data");
    assert_right_full_R4: assert (!(out_en && !wrap_mode && !norm_en && shift_right && shift_code == '0)
                                  || result == {H{sign_in}})
      else $error("full right shift not sign filled");
    assert_norm_top_R8: assert (!(out_en && norm_en && !wrap_mode && !shift_right && !sign_in
                                  && upper_sel && data_in != '0) || result[H-1])
      else $error("normalized word lacks leading one");
  end
endmodule

bind lsh_norm_shifter lsh_norm_shifter_chk #(.W(W), .H(H), .CW(CW)) u_chk (
  .data_in      (data_in),
  .sign_in      (sign_in),
  .shift_code   (shift_code),
  .shift_right  (shift_right),
  .wrap_mode    (wrap_mode),
  .norm_en      (norm_en),
  .upper_sel    (upper_sel),
  .out_en       (out_en),
  .result       (result),
  .result_valid (result_valid),
  .lead_code    (lead_code)
);

// File: tb/sim_lsh_norm_shifter.sv
`timescale 1ns/1ps
module sim_lsh_norm_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data_in = '0;
  logic        sign_in = 1'b0;
  logic [4:0]  shift_code = '0;
  logic        shift_right = 1'b0;
  logic        wrap_mode = 1'b0;
  logic        norm_en = 1'b0;
  logic        upper_sel = 1'b0;
  logic        out_en = 1'b0;
  logic [15:0] result;
  logic        result_valid;
  logic [4:0]  lead_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsh_norm_shifter u0 (
    .data_in(data_in), .sign_in(sign_in), .shift_code(shift_code),
    .shift_right(shift_right), .wrap_mode(wrap_mode), .norm_en(norm_en),
    .upper_sel(upper_sel), .out_en(out_en), .result(result),
    .result_valid(result_valid), .lead_code(lead_code)
  );

  // 32-bit field from the requirement definitions
  function automatic logic [31:0] model_field(input logic [31:0] d, input logic s,
                                              input logic [4:0] c, input logic rt,
                                              input logic wr);
    logic [95:0] big;
    logic [31:0] f;
    int amt;
    big = {{32{s}}, d, 32'b0};
    amt = rt ? int'(c) - 32 : int'(c);
    for (int j = 0; j < 32; j++) begin
      if (wr) f[j] = d[(j - int'(c) + 64) % 32];
      else    f[j] = big[32 + j - amt];
    end
    return f;
  endfunction

  function automatic logic [4:0] model_lead(input logic [31:0] d, input logic s);
    logic [31:0] m;
    m = s ? ~d : d;
    for (int i = 31; i >= 0; i--) if (m[i]) return 5'(31 - i);
    return 5'd31;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] d, input logic s, input logic [4:0] c,
                       input logic rt, input logic wr, input logic nm,
                       input logic up, input logic en);
    @(negedge clk);
    data_in = d; sign_in = s; shift_code = c; shift_right = rt;
    wrap_mode = wr; norm_en = nm; upper_sel = up; out_en = en;
    #1;
  endtask

  function automatic logic [15:0] pick(input logic [31:0] f, input logic up);
    return up ? f[31:16] : f[15:0];
  endfunction

  task automatic t_idle();
    apply(32'h1234_5678, 1'b0, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(32'(result), 32'h0, "R9 idle result");
    chk(32'(result_valid), 32'h0, "R9 idle valid");
    chk(32'(lead_code), 32'd3, "R9 lead while idle");
    apply(32'h1234_5678, 1'b0, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(32'(result_valid), 32'h1, "R9 valid when enabled");
  endtask

  task automatic t_wrap();
    for (int n = 0; n < 3; n++) begin
      logic [31:0] d;
      d = $urandom();
      for (int c = 0; c < 32; c++)
        for (int rt = 0; rt < 2; rt++)
          for (int up = 0; up < 2; up++) begin
            apply(d, 1'(n), 5'(c), 1'(rt), 1'b1, 1'b0, 1'(up), 1'b1);
            chk(32'(result), 32'(pick(model_field(d, 1'(n), 5'(c), 1'b0, 1'b1), 1'(up))),
                "R2 rotate");
          end
    end
  endtask

  task automatic t_fill();
    for (int n = 0; n < 4; n++) begin
      logic [31:0] d;
      logic s;
      d = $urandom();
      s = n[0];
      for (int c = 0; c < 64; c++)
        for (int up = 0; up < 2; up++) begin
          apply(d, s, c[4:0], c[5], 1'b0, 1'b0, 1'(up), 1'b1);
          chk(32'(result), 32'(pick(model_field(d, s, c[4:0], c[5], 1'b0), 1'(up))),
              c[5] ? "R4 right fill" : "R3 left fill");
        end
    end
  endtask

  task automatic t_corners();
    apply(32'h0000_0001, 1'b1, 5'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(32'(result), 32'h0002, "R1 left by one");
    apply(32'h8000_0000, 1'b1, 5'd31, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(32'(result), 32'hC000, "R1 code 11111 right by one");
    apply(32'h0000_0000, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(32'(result), 32'hFFFF, "R4 full right all sign");
    apply(32'hFFFF_FFFF, 1'b0, 5'd16, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(32'(result), 32'h0000, "R3 lower half zero filled");
    apply(32'hABCD_1234, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(32'(result), 32'hABCD, "R5 upper half");
    apply(32'hABCD_1234, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(32'(result), 32'h1234, "R5 lower half");
  endtask

  task automatic t_enc();
    apply(32'h8000_0000, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(32'(lead_code), 32'd0, "R6 bit31 set");
    apply(32'h0000_0001, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(32'(lead_code), 32'd31, "R6 only bit0");
    apply(32'h0000_0000, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(32'(lead_code), 32'd31, "R6 zero word");
    apply(32'h7FFF_FFFF, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(32'(lead_code), 32'd0, "R6 inverted top");
    apply(32'hFFF0_0000, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(32'(lead_code), 32'd12, "R6 negative value");
    for (int n = 0; n < 20; n++) begin
      logic [31:0] d;
      d = $urandom() >> (n % 32);
      apply(d, 1'(n), 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk(32'(lead_code), 32'(model_lead(d, 1'(n))), "R6 random");
    end
  endtask

  task automatic t_raw();
    for (int c = 0; c < 32; c += 5) begin
      apply(32'h5A5A_C3C3, 1'b1, 5'(c), 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
      chk(32'(result), 32'(pick(model_field(32'h5A5A_C3C3, 1'b0, 5'(c), 1'b0, 1'b1), 1'b1)),
          "R7 sign ignored by rotate");
      apply(32'h5A5A_C3C3, 1'b1, 5'(c), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk(32'(result), 32'(pick(32'h5A5A_C3C3 << c, 1'b0)), "R7 raw data left shift");
    end
  endtask

  task automatic t_norm();
    for (int n = 0; n < 24; n++) begin
      logic [31:0] d;
      logic [4:0]  k;
      d = $urandom() >> (n + 1);
      k = model_lead(d, 1'b0);
      for (int up = 0; up < 2; up++) begin
        apply(d, 1'b0, 5'(n), 1'b0, 1'b0, 1'b1, 1'(up), 1'b1);
        chk(32'(result), 32'(pick(d << k, 1'(up))), "R8 normalize");
      end
    end
  endtask

  initial begin
    #9 rst_n = 1'b1;
    t_idle();
    t_wrap();
    t_fill();
    t_corners();
    t_enc();
    t_raw();
    t_norm();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule